// File: doc/BRIEF.md
# Multi-Bank RAM Request Controller

This block lets five independent requesters share three single-port RAM banks of 8-bit words. Each requester drives a 16-bit address, a read/write flag and write data, with a valid/ready handshake. The top two address bits pick the bank and the lower fourteen pick the word inside it. When several requesters aim at one bank in the same cycle, a round-robin arbiter for that bank picks one of them. The others see ready low and wait, and an overflow flag for that bank is raised for the cycle.

Every accepted request gets exactly one response on the requester's own response port, a fixed six cycles after acceptance. Because the delay is the same for every request, each requester receives its responses in the order it issued the requests. A read returns the bank contents as they stood at acceptance. A write returns an acknowledge. A request that names a bank that does not exist, or a word beyond the implemented storage depth, is accepted at once and answered with an error flag. It touches no memory.

The word field is 14 bits, which addresses 16K words per bank. The implemented depth is the parameter `MEM_AW`. Setting it to 14 gives full 16K x 8 banks. The default of 10 keeps elaboration small.

Top module: `mbank_ctrl`

## Requirements
- R1: While reset is held with no request valid, all ready, response-valid and overflow outputs are low. After reset every bank's round-robin search starts at requester 0.
- R2: Address bits [15:14] select the bank (0 to 2 exist). Bits [13:0] give the word, and the low `MEM_AW` bits of the word index the storage.
- R3: A bank grants at most one requester per cycle and always grants one if any valid request targets it. The search starts at the bank's pointer. After a grant to requester i, the pointer moves to requester i+1 (wrapping after 4).
- R4: A request is accepted in a cycle where its valid and ready are both high. Ready is never high without valid. A requester that was not accepted keeps its request unchanged.
- R5: An accepted request's response-valid is high for exactly one cycle, six cycles after the cycle of acceptance, on that requester's port.
- R6: A read returns the data of the most recent write to the same bank and word that was accepted in an earlier cycle, whichever requester wrote it.
- R7: A write response has the write flag set and zero data. A read response has the write flag clear.
- R8: A request to bank field value 3, or to a word with a nonzero bit at or above `MEM_AW`, is accepted in the same cycle regardless of other traffic. It changes no memory and its response carries the error flag with zero data.
- R9: A bank's overflow bit is high in each cycle where two or more valid, in-range requests target that bank.
- R10: No response-valid appears unless a request was accepted six cycles earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 5 | Request valid per requester |
| req_ready | output | 5 | Request accepted this cycle when high together with valid |
| req_write | input | 5 | 1 = write, 0 = read |
| req_addr | input | 5x16 | Per-requester address: bank in [15:14], word in [13:0] |
| req_wdata | input | 5x8 | Per-requester write data |
| rsp_valid | output | 5 | One-cycle response pulse per requester |
| rsp_write | output | 5 | Response belongs to a write |
| rsp_err | output | 5 | Request was out of range |
| rsp_rdata | output | 5x8 | Read data, zero for writes and errors |
| bank_ovf | output | 3 | Per-bank contention flag for the current cycle |

## Verification
The assertions assume that a requester denied ready leaves its request unchanged until it is accepted. The rotation property relies on this, because it only means something when the same contending set is seen in two consecutive cycles. The stimulus keeps a pending request per requester and changes it only after acceptance, so losers always hold. The assertions also assume that the request inputs settle before the clock edge. The bench drives them on the falling edge and reads the combinational ready a moment later.

// File: rtl/mbank_pkg.sv
package mbank_pkg;
  localparam int ADDR_W = 16;
  localparam int SEL_W  = 2;
  localparam int WORD_W = ADDR_W - SEL_W;
  localparam int DATA_W = 8;

  typedef logic [SEL_W-1:0]  bank_sel_t;
  typedef logic [WORD_W-1:0] word_t;

  // bank number carried in the top address bits
  function automatic bank_sel_t bank_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:WORD_W];
  endfunction

  // word offset inside the selected bank
  function automatic word_t word_of(input logic [ADDR_W-1:0] a);
    return a[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/mbank_arb.sv
module mbank_arb #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr;

  // first requester at or after the pointer, wrapping around
  function automatic logic [N-1:0] rr_pick(input logic [N-1:0] r, input logic [PW-1:0] p);
    logic [N-1:0] g;
    logic         found;
    g     = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      int idx;
      idx = int'(p) + i;
      if (idx >= N) idx = idx - N;
      if (!found && r[idx]) begin
        g[idx] = 1'b1;
        found  = 1'b1;
      end
    end
    return g;
  endfunction

  function automatic logic [PW-1:0] after_winner(input logic [N-1:0] g, input logic [PW-1:0] p);
    logic [PW-1:0] np;
    np = p;
    for (int i = 0; i < N; i++)
      if (g[i]) np = (i == N-1) ? '0 : PW'(i + 1);
    return np;
  endfunction

  assign grant = rr_pick(req, ptr);

  always_ff @(posedge clk) begin
    if (!rst_n)      ptr <= '0;
    else if (|grant) ptr <= after_winner(grant, ptr);
  end

  // R3: one winner per bank and cycle
  a_r3_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R3: grants only go to requesters, and a request never goes unserved
  a_r3_work_conserving: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ~req) == '0) && ((|req) == (|grant)));

  // R3: the same contending set never gets the same winner twice in a row
  a_r3_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(req) > 1) |=> (!$stable(req) || (grant != $past(grant))));
endmodule

// File: rtl/mbank_mem.sv
module mbank_mem #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (en && we) store[addr] <= wdata;
  end

  // read reflects contents before this cycle's write
  assign rdata = store[addr];
endmodule

// File: rtl/mbank_rsp_pipe.sv
module mbank_rsp_pipe #(
  parameter int LAT = 6,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          wr,
  input  logic          err,
  input  logic [DW-1:0] rd,
  output logic          rsp_valid,
  output logic          rsp_write,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_data
);
  localparam int CW = $clog2(LAT + 1);

  typedef struct packed {
    logic          v;
    logic          w;
    logic          e;
    logic [DW-1:0] d;
  } stage_t;

  stage_t st [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) st[i] <= '0;
    end else begin
      st[0].v <= acc;
      st[0].w <= acc & wr;
      st[0].e <= acc & err;
      st[0].d <= (acc && !wr && !err) ? rd : '0;
      for (int i = 1; i < LAT; i++) st[i] <= st[i-1];
    end
  end

  assign rsp_valid = st[LAT-1].v;
  assign rsp_write = st[LAT-1].w;
  assign rsp_err   = st[LAT-1].e;
  assign rsp_data  = st[LAT-1].d;

  // cycles since reset, saturating, for the latency check
  logic [CW-1:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n)                  since_rst <= '0;
    else if (since_rst != CW'(LAT)) since_rst <= since_rst + 1'b1;
  end

  // R10: no response before an acceptance can have travelled the pipe
  a_r10_no_early_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (since_rst == CW'(LAT)));

  // R7: a write response never carries data
  a_r7_write_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_write) |-> (rsp_data == '0));
endmodule

// File: rtl/mbank_ctrl.sv
module mbank_ctrl
  import mbank_pkg::*;
#(
  parameter int N_REQ  = 5,
  parameter int N_BANK = 3,
  parameter int MEM_AW = 10,
  parameter int LAT    = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_REQ-1:0]              req_valid,
  output logic [N_REQ-1:0]              req_ready,
  input  logic [N_REQ-1:0]              req_write,
  input  logic [N_REQ-1:0][ADDR_W-1:0]  req_addr,
  input  logic [N_REQ-1:0][DATA_W-1:0]  req_wdata,
  output logic [N_REQ-1:0]              rsp_valid,
  output logic [N_REQ-1:0]              rsp_write,
  output logic [N_REQ-1:0]              rsp_err,
  output logic [N_REQ-1:0][DATA_W-1:0]  rsp_rdata,
  output logic [N_BANK-1:0]             bank_ovf
);
  logic [N_BANK-1:0][N_REQ-1:0] hit;
  logic [N_BANK-1:0][N_REQ-1:0] gnt;
  logic [N_REQ-1:0]             range_bad;
  logic [N_REQ-1:0]             err_req;
  logic [N_REQ-1:0]             any_gnt;
  logic [N_REQ-1:0]             acc;
  logic [DATA_W-1:0]            bank_rd [N_BANK];

  // per-requester address decode
  for (genvar r = 0; r < N_REQ; r++) begin : g_dec
    if (MEM_AW < WORD_W) begin : g_deep
      assign range_bad[r] = |req_addr[r][WORD_W-1:MEM_AW];
    end else begin : g_full
      assign range_bad[r] = 1'b0;
    end
    assign err_req[r] = req_valid[r] &
                        ((int'(bank_of(req_addr[r])) >= N_BANK) | range_bad[r]);
  end

  // one arbiter, one storage array per bank
  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    logic [MEM_AW-1:0] sel_addr;
    logic              sel_we;
    logic [DATA_W-1:0] sel_wd;

    for (genvar r = 0; r < N_REQ; r++) begin : g_hit
      assign hit[b][r] = req_valid[r] && !range_bad[r] &&
                         (bank_of(req_addr[r]) == SEL_W'(b));
    end

    mbank_arb #(.N(N_REQ)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (hit[b]),
      .grant (gnt[b])
    );

    always_comb begin
      sel_addr = '0;
      sel_we   = 1'b0;
      sel_wd   = '0;
      for (int r = 0; r < N_REQ; r++) begin
        if (gnt[b][r]) begin
          sel_addr = req_addr[r][MEM_AW-1:0];
          sel_we   = req_write[r];
          sel_wd   = req_wdata[r];
        end
      end
    end

    mbank_mem #(.AW(MEM_AW), .DW(DATA_W)) u_mem (
      .clk   (clk),
      .en    (|gnt[b]),
      .we    (sel_we),
      .addr  (sel_addr),
      .wdata (sel_wd),
      .rdata (bank_rd[b])
    );

    assign bank_ovf[b] = $countones(hit[b]) > 1;

    // R9: a flagged bank still serves exactly one requester
    a_r9_ovf_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      bank_ovf[b] |-> ($countones(gnt[b]) == 1));
  end

  always_comb begin
    any_gnt = '0;
    for (int b = 0; b < N_BANK; b++) any_gnt = any_gnt | gnt[b];
  end

  assign req_ready = err_req | any_gnt;
  assign acc       = req_valid & req_ready;

  // response pipes, one per requester
  for (genvar r = 0; r < N_REQ; r++) begin : g_rsp
    logic [DATA_W-1:0] rd_sel;

    always_comb begin
      rd_sel = '0;
      for (int b = 0; b < N_BANK; b++)
        if (bank_of(req_addr[r]) == SEL_W'(b)) rd_sel = bank_rd[b];
    end

    mbank_rsp_pipe #(.LAT(LAT), .DW(DATA_W)) u_pipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc       (acc[r]),
      .wr        (req_write[r]),
      .err       (err_req[r]),
      .rd        (rd_sel),
      .rsp_valid (rsp_valid[r]),
      .rsp_write (rsp_write[r]),
      .rsp_err   (rsp_err[r]),
      .rsp_data  (rsp_rdata[r])
    );

    // R4: ready only answers a valid request
    a_r4_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready[r] |-> req_valid[r]);

    // R8: an out-of-range request never reaches a bank arbiter's grant
    a_r8_err_no_bank: assert property (@(posedge clk) disable iff (!rst_n)
      err_req[r] |-> !any_gnt[r]);
  end
endmodule

// File: tb/mbank_ctrl_tb.sv
module mbank_ctrl_tb;
  import mbank_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NR  = 5;
  localparam int NB  = 3;
  localparam int MAW = 10;
  localparam int LAT = 6;
  localparam int NW  = 8;

  logic                       clk;
  logic                       rst_n;
  logic [NR-1:0]              req_valid;
  logic [NR-1:0]              req_ready;
  logic [NR-1:0]              req_write;
  logic [NR-1:0][ADDR_W-1:0]  req_addr;
  logic [NR-1:0][DATA_W-1:0]  req_wdata;
  logic [NR-1:0]              rsp_valid;
  logic [NR-1:0]              rsp_write;
  logic [NR-1:0]              rsp_err;
  logic [NR-1:0][DATA_W-1:0]  rsp_rdata;
  logic [NB-1:0]              bank_ovf;

  mbank_ctrl #(.N_REQ(NR), .N_BANK(NB), .MEM_AW(MAW), .LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .bank_ovf(bank_ovf)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;

  // bench model state
  int mdl [NB][NW];
  int ptr_m [NB];
  int pv [NR]; int pb [NR]; int pk [NR]; int pw [NR]; int pd [NR]; int po [NR];
  int sv [NR][8]; int sw [NR][8]; int se [NR][8]; int sd [NR][8];
  int cyc  = 0;
  int fidx = 0;
  logic [31:0] seed = 32'h1234_5679;

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  function automatic int rnd(input int m);
    seed = xs(seed);
    return int'(seed[30:0]) % m;
  endfunction

  // word index 0..6 maps to itself, index 7 to the deepest stored word
  function automatic int waddr(input int k);
    return (k < NW-1) ? k : (1 << MAW) - 1;
  endfunction

  task automatic chk(input string tag, input string what, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", tag, what, got, exp, cyc);
    end
  endtask

  task automatic step(input int mode);
    int exp_rdy;
    int exp_ovf;
    int s;
    int any_p;
    @(negedge clk);
    // registered responses for this cycle
    for (int r = 0; r < NR; r++) begin
      chk("R5 R10", $sformatf("rsp_valid[%0d]", r), int'(rsp_valid[r]), sv[r][cyc%8]);
      chk("R7", $sformatf("rsp_write[%0d]", r), int'(rsp_write[r]), sw[r][cyc%8]);
      chk("R8", $sformatf("rsp_err[%0d]", r), int'(rsp_err[r]), se[r][cyc%8]);
      chk("R2 R6", $sformatf("rsp_rdata[%0d]", r), int'(rsp_rdata[r]), sd[r][cyc%8]);
      sv[r][cyc%8] = 0; sw[r][cyc%8] = 0; se[r][cyc%8] = 0; sd[r][cyc%8] = 0;
    end
    // new requests only for requesters with nothing pending (R4 hold)
    any_p = 0;
    for (int r = 0; r < NR; r++) any_p += pv[r];
    if (mode == 0 && any_p == 0 && fidx < NB*NW) begin
      int r;
      r = fidx % NR;
      pv[r] = 1; pb[r] = fidx / NW; pk[r] = fidx % NW; pw[r] = 1;
      pd[r] = (fidx * 37 + 11) % 256; po[r] = 0;
      fidx++;
    end
    for (int r = 0; r < NR; r++) begin
      if (pv[r] == 0 && mode == 1 && rnd(8) < 5) begin
        pv[r] = 1; pb[r] = rnd(4); pk[r] = rnd(NW); pw[r] = rnd(2);
        pd[r] = rnd(256); po[r] = (rnd(16) == 0) ? 1 : 0;
      end
      if (pv[r] == 0 && mode == 2) begin
        pv[r] = 1; pb[r] = 1; pk[r] = rnd(NW); pw[r] = rnd(2);
        pd[r] = rnd(256); po[r] = 0;
      end
    end
    for (int r = 0; r < NR; r++) begin
      req_valid[r] = (pv[r] != 0);
      req_write[r] = (pw[r] != 0);
      req_wdata[r] = 8'(pd[r]);
      req_addr[r]  = {2'(pb[r]), 14'(po[r] != 0 ? (32'h2000 | waddr(pk[r])) : waddr(pk[r]))};
    end
    #1;
    // expected arbitration from the round-robin rule
    exp_rdy = 0;
    exp_ovf = 0;
    for (int r = 0; r < NR; r++)
      if (pv[r] != 0 && (pb[r] == 3 || po[r] != 0)) exp_rdy |= (1 << r);
    for (int b = 0; b < NB; b++) begin
      int hitc;
      int win;
      hitc = 0;
      win  = -1;
      for (int i = 0; i < NR; i++) begin
        int idx;
        idx = (ptr_m[b] + i) % NR;
        if (pv[idx] != 0 && po[idx] == 0 && pb[idx] == b) begin
          hitc++;
          if (win < 0) win = idx;
        end
      end
      if (hitc > 1) exp_ovf |= (1 << b);
      if (win >= 0) begin
        exp_rdy |= (1 << win);
        ptr_m[b] = (win + 1) % NR;
      end
    end
    chk("R3 R4", "req_ready", int'(req_ready), exp_rdy);
    chk("R9", "bank_ovf", int'(bank_ovf), exp_ovf);
    // expected responses, reads before writes of this cycle
    s = (cyc + LAT) % 8;
    for (int r = 0; r < NR; r++) begin
      if (((exp_rdy >> r) & 1) != 0) begin
        int e;
        e = (pb[r] == 3 || po[r] != 0) ? 1 : 0;
        sv[r][s] = 1;
        sw[r][s] = pw[r];
        se[r][s] = e;
        sd[r][s] = (pw[r] == 0 && e == 0) ? mdl[pb[r]][pk[r]] : 0;
      end
    end
    for (int r = 0; r < NR; r++) begin
      if (((exp_rdy >> r) & 1) != 0) begin
        if (pw[r] != 0 && pb[r] != 3 && po[r] == 0) mdl[pb[r]][pk[r]] = pd[r];
        pv[r] = 0;
      end
    end
    cyc++;
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = '0; req_write = '0; req_addr = '0; req_wdata = '0;
    for (int b = 0; b < NB; b++) begin
      ptr_m[b] = 0;
      for (int k = 0; k < NW; k++) mdl[b][k] = 0;
    end
    for (int r = 0; r < NR; r++) begin
      pv[r] = 0; pb[r] = 0; pk[r] = 0; pw[r] = 0; pd[r] = 0; po[r] = 0;
      for (int j = 0; j < 8; j++) begin sv[r][j] = 0; sw[r][j] = 0; se[r][j] = 0; sd[r][j] = 0; end
    end
    repeat (3) @(negedge clk);
    chk("R1", "ready in reset", int'(req_ready), 0);
    chk("R1", "rsp_valid in reset", int'(rsp_valid), 0);
    chk("R1", "bank_ovf in reset", int'(bank_ovf), 0);
    rst_n = 1'b1;
    repeat (40)   step(0);   // fill every used word with a known value
    repeat (3000) step(1);   // mixed traffic, errors, cross-requester hazards
    repeat (300)  step(2);   // all requesters on one bank
    repeat (500)  step(1);
    repeat (12)   step(3);   // drain
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule